// File: doc/BRIEF.md
# Deferred-Store Instruction Memory

This block is the backing store that holds spilled instruction-cell images. Each group in the store holds one complete cell image of three words: the instruction word and its two operand words. A group is named by the address of its first word. Throughout this block that address is carried as a group index, which is the word address divided by three.

The block has three ports. Requests arrive on the command port and are either a retrieve or a store commit. A retrieve returns the group's current image on the read-out port, tagged with the group index. Cell images that are to be written arrive separately on the data port and are parked in a small associative pending buffer. They reach the store only when a store commit for the same group is accepted on the command port.

Commands are served strictly in arrival order, one per cycle. Because of this, a retrieve that was accepted before a commit always sees the old image, and a retrieve accepted after the commit sees the new one. A commit whose data has not yet been parked holds the command port until that data arrives. The data port applies back-pressure when the pending buffer is full, and also when it already holds an image for the same group.

Top module: `deferred_imem`

## Requirements
- R1: After reset, with no command and no data presented, `rd_valid` is 0, `st_ready` is 1 and `cmd_ready` is 1.
- R2: A retrieve accepted at a clock edge (`cmd_valid`=1, `cmd_ready`=1, `cmd_store`=0) makes `rd_valid` 1 for exactly the following cycle. In that cycle `rd_grp` equals the requested group and `rd_data` equals the group's image.
- R3: An image accepted on the data port leaves the store unchanged until its commit. A retrieve of that group made before the commit returns the previous image.
- R4: A store commit (`cmd_store`=1) that is accepted while an image for that group is parked writes that image into the group. Every later retrieve of the group returns it.
- R5: A store commit for a group with no parked image keeps `cmd_ready` at 0 and produces no read-out. Once the image is accepted on the data port, the commit is accepted and takes effect.
- R6: A retrieve accepted before a commit to the same group returns the image from before the commit, even when the new image is already parked.
- R7: `st_ready` is 0 while all pending entries are occupied. It is also 0 while `st_grp` matches a group that already has a parked image.
- R8: An accepted commit frees its pending entry, so `st_ready` returns to 1 in the next cycle when no other condition blocks it.
- R9: The image layout is fixed. Word 0, the instruction, is `[W-1:0]`; operand word 1 is `[2W-1:W]`; operand word 2 is `[3W-1:2W]`. All three words are stored and returned bit for bit, and writing one group never alters another group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted at this edge |
| cmd_store | input | 1 | 1 = store commit, 0 = retrieve |
| cmd_grp | input | AW | Group index of the command |
| st_valid | input | 1 | Image present on data port |
| st_ready | output | 1 | Data port can accept |
| st_grp | input | AW | Group index of the image |
| st_data | input | 3*W | Cell image to park |
| rd_valid | output | 1 | Read-out valid |
| rd_grp | output | AW | Group index of read-out |
| rd_data | output | 3*W | Retrieved cell image |

## Verification
The bench preloads every group through the park-and-commit path, using patterns derived arithmetically from the group and word numbers. It then sweeps all groups, so a design that swapped words or aliased groups would return a wrong image. It retrieves a group while a new image is parked, and again immediately before the commit. A design that wrote on arrival of the data, or that let the commit overtake the retrieve, would return the new image too early. It also sends a commit with no image parked: a design that committed stale buffer contents would return garbage, and one that dropped the commit would never update. Finally it fills the buffer and offers a duplicate group, which catches overwrite of a parked image and missing back-pressure.

// File: rtl/dimem_pkg.sv
package dimem_pkg;
  localparam int unsigned WORDS_PER_GRP = 3;
  typedef enum logic {
    CMD_RETRIEVE = 1'b0,
    CMD_STORE    = 1'b1
  } cmd_kind_e;
endpackage

// File: rtl/dimem_rst_sync.sv
module dimem_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_sync = sh_q[1];
endmodule

// File: rtl/dimem_pend.sv
module dimem_pend #(
  parameter int unsigned AW    = 4,
  parameter int unsigned DW    = 48,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_en,
  input  logic [AW-1:0] ins_grp,
  input  logic [DW-1:0] ins_data,
  input  logic [AW-1:0] look_grp,
  input  logic          rel_en,
  output logic          full,
  output logic          dup,
  output logic          hit,
  output logic [DW-1:0] hit_data
);
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [DEPTH-1:0] free_oh, look_oh, dup_oh;
  logic [AW-1:0]    grp_q [DEPTH];
  logic [DW-1:0]    dat_q [DEPTH];

  // associative compare per entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign look_oh[i] = vld_q[i] && (grp_q[i] == look_grp);
    assign dup_oh[i]  = vld_q[i] && (grp_q[i] == ins_grp);
  end

  // lowest free entry, one-hot
  always_comb begin
    logic found;
    found   = 1'b0;
    free_oh = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !found) begin
        free_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hit_data = hit_data | (dat_q[i] & {DW{look_oh[i]}});
    end
  end

  assign full = &vld_q;
  assign dup  = |dup_oh;
  assign hit  = |look_oh;

  always_comb begin
    vld_d = vld_q;
    if (rel_en) vld_d = vld_d & ~look_oh;
    if (ins_en) vld_d = vld_d | free_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // payload registers: no reset, loaded under enable
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (ins_en && free_oh[i]) begin
        grp_q[i] <= ins_grp;
        dat_q[i] <= ins_data;
      end
    end
  end
endmodule

// File: rtl/dimem_bank.sv
module dimem_bank #(
  parameter int unsigned AW     = 4,
  parameter int unsigned WW     = 16,
  parameter int unsigned GROUPS = 16
) (
  input  logic                                      clk,
  input  logic                                      wr_en,
  input  logic [AW-1:0]                             wr_grp,
  input  logic [dimem_pkg::WORDS_PER_GRP*WW-1:0]    wr_data,
  input  logic                                      rd_en,
  input  logic [AW-1:0]                             rd_grp,
  output logic [dimem_pkg::WORDS_PER_GRP*WW-1:0]    rd_data
);
  import dimem_pkg::*;

  // one lane per word of the cell image
  for (genvar k = 0; k < WORDS_PER_GRP; k++) begin : g_lane
    logic [WW-1:0] mem [GROUPS];
    logic [WW-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_en) mem[wr_grp] <= wr_data[k*WW +: WW];
    end

    always_ff @(posedge clk) begin
      if (rd_en) rd_q <= mem[rd_grp];
    end

    assign rd_data[k*WW +: WW] = rd_q;
  end
endmodule

// File: rtl/dimem_seq.sv
module dimem_seq #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_store,
  input  logic [AW-1:0] cmd_grp,
  input  logic          hit,
  output logic          cmd_ready,
  output logic          wr_en,
  output logic          rd_en,
  output logic          rd_valid,
  output logic [AW-1:0] rd_grp
);
  import dimem_pkg::*;

  cmd_kind_e     kind;
  logic          rdv_d, rdv_q;
  logic [AW-1:0] rdg_q;

  always_comb begin
    kind      = cmd_kind_e'(cmd_store);
    cmd_ready = !cmd_valid || (kind == CMD_RETRIEVE) || hit;
    wr_en     = cmd_valid && (kind == CMD_STORE) && hit;
    rd_en     = cmd_valid && (kind == CMD_RETRIEVE);
    rdv_d     = rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdv_q <= 1'b0;
    else        rdv_q <= rdv_d;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdg_q <= cmd_grp;
  end

  assign rd_valid = rdv_q;
  assign rd_grp   = rdg_q;
endmodule

// File: rtl/deferred_imem.sv
module deferred_imem #(
  parameter int unsigned W      = 16,
  parameter int unsigned GROUPS = 16,
  parameter int unsigned PEND   = 4,
  parameter int unsigned AW     = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_store,
  input  logic [AW-1:0]       cmd_grp,
  input  logic                st_valid,
  output logic                st_ready,
  input  logic [AW-1:0]       st_grp,
  input  logic [3*W-1:0]      st_data,
  output logic                rd_valid,
  output logic [AW-1:0]       rd_grp,
  output logic [3*W-1:0]      rd_data
);
  import dimem_pkg::*;
  localparam int unsigned DW = WORDS_PER_GRP * W;

  logic          rst_n_i;
  logic          buf_full, buf_dup, buf_hit;
  logic [DW-1:0] buf_data;
  logic          ins_en, wr_en, rd_en;

  dimem_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign st_ready = !buf_full && !buf_dup;
  assign ins_en   = st_valid && st_ready;

  dimem_pend #(.AW(AW), .DW(DW), .DEPTH(PEND)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .ins_en   (ins_en),
    .ins_grp  (st_grp),
    .ins_data (st_data),
    .look_grp (cmd_grp),
    .rel_en   (wr_en),
    .full     (buf_full),
    .dup      (buf_dup),
    .hit      (buf_hit),
    .hit_data (buf_data)
  );

  dimem_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .cmd_valid (cmd_valid),
    .cmd_store (cmd_store),
    .cmd_grp   (cmd_grp),
    .hit       (buf_hit),
    .cmd_ready (cmd_ready),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_valid  (rd_valid),
    .rd_grp    (rd_grp)
  );

  dimem_bank #(.AW(AW), .WW(W), .GROUPS(GROUPS)) u_bank (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_grp  (cmd_grp),
    .wr_data (buf_data),
    .rd_en   (rd_en),
    .rd_grp  (cmd_grp),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/dimem_chk.sv
module dimem_chk #(
  parameter int unsigned AW   = 4,
  parameter int unsigned PEND = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_store,
  input logic [AW-1:0] cmd_grp,
  input logic          st_valid,
  input logic          st_ready,
  input logic          rd_valid,
  input logic [AW-1:0] rd_grp,
  input logic          buf_hit
);
  localparam int unsigned CW = $clog2(PEND + 2);
  logic [CW-1:0] occ_q;
  logic          retr_acc, commit_acc, park_acc;

  assign retr_acc   = cmd_valid && cmd_ready && !cmd_store;
  assign commit_acc = cmd_valid && cmd_ready && cmd_store;
  assign park_acc   = st_valid && st_ready;

  // independent occupancy count of the pending buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_q + CW'(park_acc) - CW'(commit_acc);
  end

  p_retr_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    retr_acc |=> (rd_valid && rd_grp == $past(cmd_grp)));

  p_no_spurious_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(retr_acc));

  p_commit_has_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_acc |-> buf_hit);

  p_stall_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_store && !cmd_ready) |=> !rd_valid);

  p_full_backpressure_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == CW'(PEND)) |-> !st_ready);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= CW'(PEND));
endmodule

bind deferred_imem dimem_chk #(.AW(AW), .PEND(PEND)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_store (cmd_store),
  .cmd_grp   (cmd_grp),
  .st_valid  (st_valid),
  .st_ready  (st_ready),
  .rd_valid  (rd_valid),
  .rd_grp    (rd_grp),
  .buf_hit   (buf_hit)
);

// File: tb/deferred_imem_tb_top.sv
module deferred_imem_tb_top;
  localparam int unsigned W      = 8;
  localparam int unsigned GROUPS = 8;
  localparam int unsigned PEND   = 2;
  localparam int unsigned AW     = 3;
  localparam int unsigned DW     = 3 * W;

  logic          clk;
  logic          rst_n;
  logic          cmd_valid, cmd_ready, cmd_store;
  logic [AW-1:0] cmd_grp;
  logic          st_valid, st_ready;
  logic [AW-1:0] st_grp;
  logic [DW-1:0] st_data;
  logic          rd_valid;
  logic [AW-1:0] rd_grp;
  logic [DW-1:0] rd_data;

  logic [DW-1:0] exp_mem [GROUPS];
  logic [DW-1:0] park    [GROUPS];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  deferred_imem #(.W(W), .GROUPS(GROUPS), .PEND(PEND), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_store(cmd_store), .cmd_grp(cmd_grp),
    .st_valid(st_valid), .st_ready(st_ready), .st_grp(st_grp), .st_data(st_data),
    .rd_valid(rd_valid), .rd_grp(rd_grp), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // image: word k of group g = (3g+k)*7 + salt, word 0 in the low bits (R9)
  function automatic logic [DW-1:0] pat(int g, int salt);
    logic [DW-1:0] v;
    for (int k = 0; k < 3; k++) v[k*W +: W] = W'((3*g + k) * 7 + salt);
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(int g, logic [DW-1:0] d);
    @(negedge clk);
    st_valid = 1'b1; st_grp = AW'(g); st_data = d;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    st_valid = 1'b0;
    park[g] = d;
  endtask

  task automatic commit(int g);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_store = 1'b1; cmd_grp = AW'(g);
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cmd_valid = 1'b0; cmd_store = 1'b0;
    exp_mem[g] = park[g];
  endtask

  task automatic retr(int g, string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_store = 1'b0; cmd_grp = AW'(g);
    #1;
    chk(cmd_ready, {req, " retrieve accepted"}, 64'(cmd_ready), 64'd1);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    chk(rd_valid && rd_grp == AW'(g) && rd_data == exp_mem[g], req,
        64'({rd_valid, rd_grp, rd_data}), 64'({1'b1, AW'(g), exp_mem[g]}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_store = 1'b0; cmd_grp = '0;
    st_valid = 1'b0; st_grp = '0; st_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(!rd_valid && st_ready && cmd_ready, "R1 reset state",
        64'({rd_valid, st_ready, cmd_ready}), 64'b011);

    // preload every group via park + commit, then sweep (R2, R4, R9)
    for (int g = 0; g < GROUPS; g++) begin
      put(g, pat(g, 0));
      commit(g);
    end
    for (int g = 0; g < GROUPS; g++) retr(g, "R2 R9 preload sweep");

    // R3: parked image is not visible before its commit
    put(2, pat(2, 100));
    retr(2, "R3 parked not yet written");
    commit(2);
    retr(2, "R4 committed image visible");
    retr(1, "R9 neighbour group untouched");
    retr(3, "R9 neighbour group untouched");

    // R6: retrieve ahead of commit sees old image, even if data parked
    put(3, pat(3, 55));
    retr(3, "R6 retrieve before commit old");
    commit(3);
    retr(3, "R6 retrieve after commit new");

    // R7: duplicate group and full buffer back-pressure
    put(4, pat(4, 9));
    @(negedge clk);
    st_valid = 1'b1; st_grp = AW'(4); st_data = pat(4, 77);
    #1 chk(!st_ready, "R7 duplicate group refused", 64'(st_ready), 64'd0);
    @(negedge clk);
    st_valid = 1'b0;
    put(5, pat(5, 9));
    @(negedge clk);
    st_valid = 1'b1; st_grp = AW'(6); st_data = pat(6, 9);
    #1 chk(!st_ready, "R7 full buffer refused", 64'(st_ready), 64'd0);
    retr(4, "R3 parked not yet written full");
    commit(4);
    @(negedge clk);
    chk(st_ready, "R8 freed entry reopens port", 64'(st_ready), 64'd1);
    @(posedge clk); #1;
    st_valid = 1'b0;
    park[6] = pat(6, 9);
    commit(5);
    commit(6);
    retr(4, "R4 commit group 4");
    retr(5, "R4 commit group 5");
    retr(6, "R4 commit group 6");

    // R5: commit with no parked image stalls, then completes
    @(negedge clk);
    cmd_valid = 1'b1; cmd_store = 1'b1; cmd_grp = AW'(7);
    for (int i = 0; i < 3; i++) begin
      #1 chk(!cmd_ready && !rd_valid, "R5 commit stalled without data",
             64'({cmd_ready, rd_valid}), 64'd0);
      @(negedge clk);
    end
    st_valid = 1'b1; st_grp = AW'(7); st_data = pat(7, 31);
    #1 chk(st_ready && !cmd_ready, "R5 data offered while stalled",
           64'({st_ready, cmd_ready}), 64'b10);
    @(posedge clk); #1;
    st_valid = 1'b0;
    @(negedge clk);
    chk(cmd_ready, "R5 commit released by data", 64'(cmd_ready), 64'd1);
    @(posedge clk); #1;
    cmd_valid = 1'b0; cmd_store = 1'b0;
    exp_mem[7] = pat(7, 31);
    retr(7, "R5 stalled commit took effect");

    // final sweep of all groups against model (R9)
    for (int g = 0; g < GROUPS; g++) retr(g, "R9 final sweep");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule